// File: doc/BRIEF.md
# Effective Address Generator with Page-Cross Detection

This unit turns an operand and the index registers of an 8-bit processor into the 16-bit address of a data access. The request arrives as a one-cycle `start` pulse. It carries an addressing-mode code, the one or two operand bytes, both index registers and a flag that marks the access as a store. Direct modes are resolved arithmetically. Pointer modes read a two-byte pointer through a simple byte-read port. When the address is ready, the unit pulses `done` and presents the address with three companion outputs: a page-crossing indication, a request for a penalty cycle, and the total cycle count that the instruction needs in this mode.

Zero-page indexing and pointer fetches inside page zero keep their arithmetic within 8 bits, so they stay in page zero. Absolute indexing and the final Y add of the post-indexed pointer mode use a full 16-bit sum. The jump-pointer mode increments only the low byte when it forms the address of the pointer's high byte, so that fetch does not leave the page. A penalty cycle is requested only for loads. Stores in indexed modes are always given the longer count.

Top module: `eff_addr_gen`

## Requirements
- R1: After reset, `done`, `busy` and `rd_req` are 0, and `addr`, `page_cross`, `extra_cycle` and `cycles` are 0.
- R2: Mode code 0 (zero page) yields address {0x00, op_lo} and a count of 3. Mode code 3 (absolute) yields {op_hi, op_lo} and a count of 4. Mode codes 9 to 15 behave as absolute.
- R3: Mode codes 1 (zero page + X) and 2 (zero page + Y) yield {0x00, (op_lo + index) mod 256} and a count of 4. Base 0x80 with index 0xFF gives 0x007F.
- R4: Mode codes 4 (absolute + X) and 5 (absolute + Y) yield the full 16-bit sum {op_hi, op_lo} + index. Base 0x0080 with X = 0xFF gives 0x017F.
- R5: `page_cross` is 1 exactly when an absolute-indexed or pointer-then-Y result has a high byte that differs from the high byte of its base. For a load, `extra_cycle` equals `page_cross`, and the count is the base count (4 or 5) plus 1 on a crossing.
- R6: For a store (`is_write` = 1), `extra_cycle` is 0 and the count is the fixed longer value whatever the crossing: 5 for modes 4 and 5, and 6 for mode 7. `page_cross` is still reported.
- R7: Mode code 6 (X then pointer) reads the pointer low byte at zero-page location (op_lo + X) mod 256. It reads the high byte at the next location modulo 256. The address is that pointer, and the count is 6.
- R8: Mode code 7 (pointer then Y) reads the pointer from zero-page locations op_lo and (op_lo + 1) mod 256, then adds Y with a full 16-bit add.
- R9: Mode code 8 (jump pointer) reads the low byte at {op_hi, op_lo} and the high byte at {op_hi, op_lo + 1 mod 256}. The result is that pointer, with a count of 5 and `page_cross` 0. A pointer at 0x30FF takes its high byte from 0x3000.
- R10: `done` is high for one cycle per accepted request. `addr`, `page_cross`, `extra_cycle` and `cycles` change only together with `done` and hold between results.
- R11: Direct modes raise `done` one cycle after `start` is sampled. Pointer modes raise it three cycles after, with one byte read in each of the two cycles in between.
- R12: While `busy` is 1, `start` is ignored: the running request completes with its own result and no second `done` follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request pulse, accepted when idle |
| mode | input | 4 | Addressing-mode code |
| is_write | input | 1 | Access is a store |
| op_lo | input | 8 | First operand byte |
| op_hi | input | 8 | Second operand byte |
| idx_x | input | 8 | X index register |
| idx_y | input | 8 | Y index register |
| rd_req | output | 1 | Pointer byte read strobe |
| rd_addr | output | 16 | Pointer byte read address |
| rd_data | input | 8 | Byte at rd_addr, valid in the same cycle |
| busy | output | 1 | Pointer fetch in progress |
| done | output | 1 | Result valid pulse |
| addr | output | 16 | Effective address |
| page_cross | output | 1 | Index add changed the high byte |
| extra_cycle | output | 1 | Load needs a penalty cycle |
| cycles | output | 3 | Total cycle count of the instruction |

## Verification
The bench first targets the wrap boundaries. Zero-page indexing from 0x80 by 0xFF, and pointers at zero-page 0xFF, show whether the design carries into page one: it would return 0x017F, or fetch a pointer high byte from 0x0100 instead of 0x0000. The jump pointer at 0x30FF catches a design that increments the full 16-bit pointer address, because its high byte then comes from 0x3100. Crossing and non-crossing pairs for loads and stores expose a penalty cycle that is charged on stores or missed on loads. Back-to-back and overlapping `start` pulses expose a lost request or a duplicated `done`.

// File: rtl/eff_addr_gen.sv
module eff_addr_gen #(
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [3:0]      mode,
  input  logic            is_write,
  input  logic [DW-1:0]   op_lo,
  input  logic [DW-1:0]   op_hi,
  input  logic [DW-1:0]   idx_x,
  input  logic [DW-1:0]   idx_y,
  output logic            rd_req,
  output logic [2*DW-1:0] rd_addr,
  input  logic [DW-1:0]   rd_data,
  output logic            busy,
  output logic            done,
  output logic [2*DW-1:0] addr,
  output logic            page_cross,
  output logic            extra_cycle,
  output logic [2:0]      cycles
);
  localparam int AW = 2*DW;
  localparam logic [3:0] M_ZP = 4'd0, M_ZPX = 4'd1, M_ZPY = 4'd2, M_ABS = 4'd3,
                         M_ABX = 4'd4, M_ABY = 4'd5, M_IZX = 4'd6, M_IZY = 4'd7,
                         M_IND = 4'd8;
  localparam logic [1:0] S_IDLE = 2'd0, S_LO = 2'd1, S_HI = 2'd2;

  logic [1:0]    st;
  logic [3:0]    mode_q;
  logic          wr_q;
  logic [DW-1:0] y_q, lo_q;
  logic [AW-1:0] plo_a, phi_a;

  logic [AW-1:0] base, sum_x, sum_y;
  logic [DW-1:0] zp_x, zp_y, zp_n;
  logic          is_ptr;

  assign base  = {op_hi, op_lo};
  assign sum_x = base + {{DW{1'b0}}, idx_x};
  assign sum_y = base + {{DW{1'b0}}, idx_y};
  assign zp_x  = op_lo + idx_x;
  assign zp_y  = op_lo + idx_y;
  assign zp_n  = op_lo + 1'b1;
  assign is_ptr = (mode == M_IZX) || (mode == M_IZY) || (mode == M_IND);

  logic [AW-1:0] d_ea;
  logic          d_pc;
  logic [2:0]    d_cyc;
  always_comb begin
    d_ea = base;
    d_pc = 1'b0;
    d_cyc = 3'd4;
    case (mode)
      M_ZP:  begin d_ea = {{DW{1'b0}}, op_lo}; d_cyc = 3'd3; end
      M_ZPX: d_ea = {{DW{1'b0}}, zp_x};
      M_ZPY: d_ea = {{DW{1'b0}}, zp_y};
      M_ABX: begin
        d_ea = sum_x;
        d_pc = sum_x[AW-1:DW] != op_hi;
        d_cyc = (is_write || d_pc) ? 3'd5 : 3'd4;
      end
      M_ABY: begin
        d_ea = sum_y;
        d_pc = sum_y[AW-1:DW] != op_hi;
        d_cyc = (is_write || d_pc) ? 3'd5 : 3'd4;
      end
      default: ;
    endcase
  end

  logic [AW-1:0] ptr, izy_sum, p_ea;
  logic          p_pc;
  logic [2:0]    p_cyc;
  assign ptr     = {rd_data, lo_q};
  assign izy_sum = ptr + {{DW{1'b0}}, y_q};
  always_comb begin
    p_ea = ptr;
    p_pc = 1'b0;
    p_cyc = 3'd5;
    case (mode_q)
      M_IZX: p_cyc = 3'd6;
      M_IZY: begin
        p_ea = izy_sum;
        p_pc = izy_sum[AW-1:DW] != rd_data;
        p_cyc = (wr_q || p_pc) ? 3'd6 : 3'd5;
      end
      default: ;
    endcase
  end

  assign busy    = st != S_IDLE;
  assign rd_req  = (st == S_LO) || (st == S_HI);
  assign rd_addr = (st == S_HI) ? phi_a : plo_a;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      mode_q <= '0;
      wr_q <= 1'b0;
      y_q <= '0;
      lo_q <= '0;
      plo_a <= '0;
      phi_a <= '0;
      done <= 1'b0;
      addr <= '0;
      page_cross <= 1'b0;
      extra_cycle <= 1'b0;
      cycles <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          mode_q <= mode;
          wr_q <= is_write;
          y_q <= idx_y;
          if (is_ptr) begin
            st <= S_LO;
            if (mode == M_IZX) begin
              plo_a <= {{DW{1'b0}}, zp_x};
              phi_a <= {{DW{1'b0}}, zp_x + 1'b1};
            end else if (mode == M_IZY) begin
              plo_a <= {{DW{1'b0}}, op_lo};
              phi_a <= {{DW{1'b0}}, zp_n};
            end else begin
              plo_a <= base;
              phi_a <= {op_hi, zp_n};
            end
          end else begin
            done <= 1'b1;
            addr <= d_ea;
            page_cross <= d_pc;
            extra_cycle <= d_pc && !is_write;
            cycles <= d_cyc;
          end
        end
        S_LO: begin
          lo_q <= rd_data;
          st <= S_HI;
        end
        default: begin
          st <= S_IDLE;
          done <= 1'b1;
          addr <= p_ea;
          page_cross <= p_pc;
          extra_cycle <= p_pc && !wr_q;
          cycles <= p_cyc;
        end
      endcase
    end
  end
endmodule

// File: rtl/eff_addr_gen_chk.sv
module eff_addr_gen_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        busy,
  input logic        done,
  input logic        rd_req,
  input logic [15:0] addr,
  input logic        page_cross,
  input logic        extra_cycle,
  input logic [2:0]  cycles,
  input logic [3:0]  mode_q,
  input logic        wr_q
);
  AST_ZP_STAYS_PAGE0: assert property (@(posedge clk) disable iff (!rst_n)
    done && (mode_q <= 4'd2) |-> addr[15:8] == 8'h00); // R3
  AST_EXTRA_NEEDS_CROSS: assert property (@(posedge clk) disable iff (!rst_n)
    extra_cycle |-> page_cross); // R5
  AST_STORE_NO_EXTRA: assert property (@(posedge clk) disable iff (!rst_n)
    done && wr_q |-> !extra_cycle); // R6
  AST_JMP_NO_CROSS: assert property (@(posedge clk) disable iff (!rst_n)
    done && (mode_q == 4'd8) |-> !page_cross && cycles == 3'd5); // R9
  AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(addr) && $stable(cycles) && $stable(page_cross)); // R10
  AST_READ_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> busy); // R11
  AST_BUSY_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start |=> !done || !busy); // R12
  AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> cycles >= 3'd3 && cycles <= 3'd6); // R2
endmodule

bind eff_addr_gen eff_addr_gen_chk chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .rd_req(rd_req), .addr(addr), .page_cross(page_cross),
  .extra_cycle(extra_cycle), .cycles(cycles), .mode_q(mode_q), .wr_q(wr_q)
);

// File: tb/eff_addr_gen_test.sv
module eff_addr_gen_test;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, is_write = 1'b0;
  logic [3:0] mode = '0;
  logic [7:0] op_lo = '0, op_hi = '0, idx_x = '0, idx_y = '0;
  logic rd_req, busy, done, page_cross, extra_cycle;
  logic [15:0] rd_addr, addr;
  logic [7:0] rd_data;
  logic [2:0] cycles;
  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  function automatic logic [7:0] mem_byte(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'hA5;
  endfunction
  assign rd_data = mem_byte(rd_addr);

  eff_addr_gen uut (.*);

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  logic [15:0] r_ea; logic r_pc, r_xc; logic [2:0] r_cyc; int r_lat;

  task automatic issue(input logic [3:0] m, input logic w, input logic [7:0] lo,
                       input logic [7:0] hi, input logic [7:0] x, input logic [7:0] y);
    @(negedge clk);
    mode = m; is_write = w; op_lo = lo; op_hi = hi; idx_x = x; idx_y = y; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    r_lat = 1;
    while (!done && r_lat < 20) begin @(negedge clk); r_lat++; end
    r_ea = addr; r_pc = page_cross; r_xc = extra_cycle; r_cyc = cycles;
  endtask

  task automatic expect_res(input string tag, input logic [15:0] ea, input logic pc,
                            input logic xc, input int cyc, input int lat);
    chk({tag, " addr"}, r_ea, ea);
    chk({tag, " page_cross"}, r_pc, pc);
    chk({tag, " extra_cycle"}, r_xc, xc);
    chk({tag, " cycles"}, r_cyc, cyc);
    chk({tag, " latency"}, r_lat, lat);
  endtask

  task automatic t_reset;
    chk("R1 done", done, 0); chk("R1 busy", busy, 0); chk("R1 rd_req", rd_req, 0);
    chk("R1 addr", addr, 0); chk("R1 cycles", cycles, 0);
    chk("R1 page_cross", page_cross, 0); chk("R1 extra_cycle", extra_cycle, 0);
  endtask

  task automatic t_direct;
    issue(4'd0, 0, 8'h44, 8'h12, 8'h00, 8'h00); expect_res("R2 zp", 16'h0044, 0, 0, 3, 1);
    issue(4'd3, 0, 8'h00, 8'h44, 8'h00, 8'h00); expect_res("R2 abs", 16'h4400, 0, 0, 4, 1);
    issue(4'd12, 0, 8'h97, 8'h55, 8'h00, 8'h00); expect_res("R2 unused code", 16'h5597, 0, 0, 4, 1);
    issue(4'd1, 0, 8'h80, 8'h00, 8'hFF, 8'h00); expect_res("R3 zpx wrap", 16'h007F, 0, 0, 4, 1);
    issue(4'd2, 1, 8'hF0, 8'h33, 8'h00, 8'h20); expect_res("R3 zpy wrap", 16'h0010, 0, 0, 4, 1);
  endtask

  task automatic t_abs_indexed;
    issue(4'd4, 0, 8'h80, 8'h00, 8'hFF, 8'h00); expect_res("R4 R5 abx cross load", 16'h017F, 1, 1, 5, 1);
    issue(4'd4, 0, 8'h10, 8'h20, 8'h05, 8'h00); expect_res("R5 abx no cross", 16'h2015, 0, 0, 4, 1);
    issue(4'd5, 0, 8'hFF, 8'hFF, 8'h00, 8'h02); expect_res("R4 aby 16-bit wrap", 16'h0001, 1, 1, 5, 1);
    issue(4'd4, 1, 8'h10, 8'h20, 8'h05, 8'h00); expect_res("R6 abx store", 16'h2015, 0, 0, 5, 1);
    issue(4'd5, 1, 8'hF0, 8'h20, 8'h00, 8'h20); expect_res("R6 aby store cross", 16'h2110, 1, 0, 5, 1);
  endtask

  task automatic t_pointer;
    logic [15:0] p;
    p = {mem_byte(16'h0000), mem_byte(16'h00FF)};
    issue(4'd6, 0, 8'hF0, 8'h00, 8'h0F, 8'h00); expect_res("R7 izx wrap", p, 0, 0, 6, 3);
    p = {mem_byte(16'h0041), mem_byte(16'h0040)};
    issue(4'd6, 1, 8'h30, 8'h00, 8'h10, 8'h00); expect_res("R7 izx store", p, 0, 0, 6, 3);
    p = {mem_byte(16'h0000), mem_byte(16'h00FF)} + 16'h00B0;
    issue(4'd7, 0, 8'hFF, 8'h00, 8'h00, 8'hB0); expect_res("R8 R5 izy cross load", p, 1, 1, 6, 3);
    p = {mem_byte(16'h0011), mem_byte(16'h0010)} + 16'h0020;
    issue(4'd7, 0, 8'h10, 8'h00, 8'h00, 8'h20); expect_res("R8 izy no cross", p, 0, 0, 5, 3);
    issue(4'd7, 1, 8'h10, 8'h00, 8'h00, 8'h20); expect_res("R6 izy store", p, 0, 0, 6, 3);
    p = {mem_byte(16'h3000), mem_byte(16'h30FF)};
    issue(4'd8, 0, 8'hFF, 8'h30, 8'h00, 8'h00); expect_res("R9 jmp ptr page end", p, 0, 0, 5, 3);
  endtask

  task automatic t_handshake;
    logic [15:0] p;
    int dones;
    p = {mem_byte(16'h0021), mem_byte(16'h0020)};
    @(negedge clk);
    mode = 4'd6; is_write = 0; op_lo = 8'h20; idx_x = 8'h00; start = 1'b1;
    @(negedge clk);
    mode = 4'd0; op_lo = 8'h99;
    chk("R11 busy after ptr start", busy, 1);
    @(negedge clk);
    chk("R11 rd_req second cycle", rd_req, 1);
    start = 1'b0;
    @(negedge clk);
    chk("R12 done ptr result", done, 1);
    chk("R12 addr of running request", addr, p);
    dones = 0;
    for (int i = 0; i < 4; i++) begin @(negedge clk); if (done) dones++; end
    chk("R12 no extra done", dones, 0);
    chk("R10 addr held", addr, p);
    issue(4'd0, 0, 8'h05, 8'h00, 8'h00, 8'h00);
    @(negedge clk); start = 1'b1; mode = 4'd0; op_lo = 8'h06;
    @(negedge clk); start = 1'b0;
    chk("R10 back-to-back done", done, 1);
    chk("R10 back-to-back addr", addr, 16'h0006);
    @(negedge clk);
    chk("R10 done one cycle", done, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_direct();
    t_abs_indexed();
    t_pointer();
    t_handshake();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #400000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule